// File: doc/BRIEF.md
# Register Alias Rename Table

This block sits in the rename stage of an out-of-order core. Each cycle it can take a group of up to three micro-ops. Every micro-op carries two source architectural register indices and an optional destination index. The block maps 8 architectural registers onto a pool of 40 physical registers. Each destination that is written gets a fresh physical tag. A micro-op that executes early therefore cannot overwrite a value that an older micro-op still has to read.

Within one group, a micro-op that reads a register written by an older member of the same group takes that member's new tag instead of the table entry. For every destination the block also reports the tag that was mapped before, called the old tag. Retirement logic hands that old tag back in order when the micro-op retires, together with the new mapping. The retirement port writes the committed map and returns the old tag to the free pool. A flush discards all speculative state in one cycle. It copies the committed map into the speculative map and rebuilds the free pool from the committed map.

Top module: `rat_top`

## Requirements
- R1: After reset, both maps hold architectural register i on physical tag i, and the free pool holds exactly tags 8 to 39.
- R2: Each accepted slot with a destination receives a free tag. Slots are served in slot order (slot 0 first), each taking the lowest-numbered tag still free, and no two slots of a group receive the same tag.
- R3: A source tag is the speculative map entry of that register, unless an older valid slot of the same group writes that register; then the source tag is the new tag of the youngest such older slot.
- R4: The old tag of a destination is the speculative map entry of that register before the group. If an older slot of the same group writes the same register, the old tag is that slot's new tag instead.
- R5: After an accepted group, the speculative map holds each written register on its new tag, and when two slots of a group write one register the younger slot wins.
- R6: outReady is low when the number of valid slots with a destination exceeds the number of free tags. While it is low, a group changes neither the maps nor the free pool. A group needing exactly the number of free tags is accepted.
- R7: A retiring entry (retValid bit set) writes retTag into the committed map for retArch and returns retOldTag to the free pool from the next cycle on.
- R8: On flush, outReady is low. From the next cycle on, the speculative map equals the committed map, including retirements presented in the flush cycle, and the free pool holds exactly the tags absent from the committed map.
- R9: A slot whose inValid bit is low, or whose inHasDst bit is low, takes no tag and changes no map entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 3 | Slot valid, bit g for slot g |
| inHasDst | input | 3 | Slot writes a destination |
| inSrcA | input | 9 | First source index per slot, slot g at bits 3g+2:3g |
| inSrcB | input | 9 | Second source index per slot |
| inDst | input | 9 | Destination index per slot |
| outReady | output | 1 | Group accepted this cycle |
| outSrcATag | output | 18 | First source tag per slot, slot g at bits 6g+5:6g |
| outSrcBTag | output | 18 | Second source tag per slot |
| outDstTag | output | 18 | New destination tag per slot |
| outOldTag | output | 18 | Previous tag of the destination per slot |
| retValid | input | 3 | Retirement entry valid |
| retArch | input | 9 | Retired architectural index per entry |
| retTag | input | 18 | Retired new tag per entry |
| retOldTag | input | 18 | Tag to free per entry |
| flush | input | 1 | Restore committed state |

## Verification
The bench builds the block with its default sizes: a group of three, 8 architectural registers and 40 physical tags. A pool of 32 free tags drains in about ten groups, so the exact-fit boundary and the one-short stall are both reached within a short run. Three slots are enough to cover a double bypass, both orders of dependence inside a group, and two slots writing one register. A flush presented together with retirements shows how the two interact.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int GROUP = 3;
  localparam int ARCH  = 8;
  localparam int PHYS  = 40;
  localparam int AW    = $clog2(ARCH);
  localparam int TW    = $clog2(PHYS);
  localparam int CW    = $clog2(PHYS + 1);

  typedef logic [AW-1:0] archIdx_t;
  typedef logic [TW-1:0] physTag_t;

  typedef struct packed {
    logic                       doRename;
    logic                       doFlush;
    logic [GROUP-1:0]           slotAlloc;
    logic [GROUP-1:0][TW-1:0]   allocTag;
  } ratStrobe_t;
endpackage

// File: rtl/rat_ctrl.sv
module rat_ctrl
  import rat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GROUP-1:0]      inValid,
  input  logic [GROUP-1:0]      inHasDst,
  input  logic [GROUP-1:0]      retValid,
  input  logic [GROUP*TW-1:0]   retOldTag,
  input  logic                  flush,
  input  logic [PHYS-1:0]       commitUsed,
  output ratStrobe_t            strobe,
  output logic                  ready,
  output logic [PHYS-1:0]       freeVec
);
  logic [PHYS-1:0] freeNext;
  logic [PHYS-1:0] remaining;
  logic [PHYS-1:0] allocMask;
  logic [PHYS-1:0] freedMask;
  logic [CW-1:0]   needCnt;
  logic [CW-1:0]   freeCnt;
  logic            found;

  always_comb begin
    needCnt = '0;
    for (int g = 0; g < GROUP; g++)
      needCnt = needCnt + CW'(inValid[g] & inHasDst[g]);
    freeCnt = '0;
    for (int p = 0; p < PHYS; p++)
      freeCnt = freeCnt + CW'(freeVec[p]);
    ready = !flush && (needCnt <= freeCnt);
  end

  always_comb begin
    remaining = freeVec;
    allocMask = '0;
    strobe.allocTag = '0;
    strobe.slotAlloc = '0;
    for (int g = 0; g < GROUP; g++) begin
      found = 1'b0;
      if (inValid[g] && inHasDst[g]) begin
        for (int p = 0; p < PHYS; p++) begin
          if (!found && remaining[p]) begin
            strobe.allocTag[g] = TW'(p);
            remaining[p] = 1'b0;
            found = 1'b1;
          end
        end
        strobe.slotAlloc[g] = ready;
        if (ready) allocMask[strobe.allocTag[g]] = 1'b1;
      end
    end
    strobe.doRename = ready && (|inValid);
    strobe.doFlush  = flush;
  end

  always_comb begin
    freedMask = '0;
    for (int g = 0; g < GROUP; g++)
      if (retValid[g]) freedMask[retOldTag[g*TW +: TW]] = 1'b1;
    if (flush) freeNext = ~commitUsed;
    else       freeNext = (freeVec & ~allocMask) | freedMask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) freeVec <= {{(PHYS-ARCH){1'b1}}, {ARCH{1'b0}}};
    else        freeVec <= freeNext;
  end
endmodule

// File: rtl/rat_dp.sv
module rat_dp
  import rat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  ratStrobe_t            strobe,
  input  logic [GROUP-1:0]      inValid,
  input  logic [GROUP-1:0]      inHasDst,
  input  logic [GROUP*AW-1:0]   inSrcA,
  input  logic [GROUP*AW-1:0]   inSrcB,
  input  logic [GROUP*AW-1:0]   inDst,
  input  logic [GROUP-1:0]      retValid,
  input  logic [GROUP*AW-1:0]   retArch,
  input  logic [GROUP*TW-1:0]   retTag,
  output logic [GROUP*TW-1:0]   outSrcATag,
  output logic [GROUP*TW-1:0]   outSrcBTag,
  output logic [GROUP*TW-1:0]   outDstTag,
  output logic [GROUP*TW-1:0]   outOldTag,
  output logic [PHYS-1:0]       commitUsed,
  output logic [ARCH*TW-1:0]    specFlat,
  output logic [ARCH*TW-1:0]    commitFlat
);
  physTag_t specMap   [ARCH];
  physTag_t commitMap [ARCH];
  physTag_t specNext  [ARCH];
  physTag_t commitNext[ARCH];
  physTag_t tagA, tagB, tagOld;
  archIdx_t srcA, srcB, dstG, dstK;

  // Lookup with bypass from older slots of the same group
  always_comb begin
    outSrcATag = '0;
    outSrcBTag = '0;
    outOldTag  = '0;
    outDstTag  = '0;
    for (int g = 0; g < GROUP; g++) begin
      srcA = inSrcA[g*AW +: AW];
      srcB = inSrcB[g*AW +: AW];
      dstG = inDst[g*AW +: AW];
      tagA = specMap[srcA];
      tagB = specMap[srcB];
      tagOld = specMap[dstG];
      for (int k = 0; k < g; k++) begin
        dstK = inDst[k*AW +: AW];
        if (inValid[k] && inHasDst[k]) begin
          if (dstK == srcA) tagA = strobe.allocTag[k];
          if (dstK == srcB) tagB = strobe.allocTag[k];
          if (dstK == dstG) tagOld = strobe.allocTag[k];
        end
      end
      outSrcATag[g*TW +: TW] = tagA;
      outSrcBTag[g*TW +: TW] = tagB;
      outOldTag[g*TW +: TW]  = tagOld;
      outDstTag[g*TW +: TW]  = strobe.allocTag[g];
    end
  end

  always_comb begin
    for (int a = 0; a < ARCH; a++) commitNext[a] = commitMap[a];
    for (int g = 0; g < GROUP; g++)
      if (retValid[g]) commitNext[retArch[g*AW +: AW]] = retTag[g*TW +: TW];
    commitUsed = '0;
    for (int a = 0; a < ARCH; a++) commitUsed[commitNext[a]] = 1'b1;
  end

  always_comb begin
    for (int a = 0; a < ARCH; a++) specNext[a] = specMap[a];
    if (strobe.doFlush) begin
      for (int a = 0; a < ARCH; a++) specNext[a] = commitNext[a];
    end else if (strobe.doRename) begin
      for (int g = 0; g < GROUP; g++)
        if (strobe.slotAlloc[g]) specNext[inDst[g*AW +: AW]] = strobe.allocTag[g];
    end
  end

  always_ff @(posedge clk) begin
    for (int a = 0; a < ARCH; a++) begin
      if (!rst_n) begin
        specMap[a]   <= TW'(a);
        commitMap[a] <= TW'(a);
      end else begin
        specMap[a]   <= specNext[a];
        commitMap[a] <= commitNext[a];
      end
    end
  end

  always_comb begin
    for (int a = 0; a < ARCH; a++) begin
      specFlat[a*TW +: TW]   = specMap[a];
      commitFlat[a*TW +: TW] = commitMap[a];
    end
  end
endmodule

// File: rtl/rat_top.sv
module rat_top
  import rat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GROUP-1:0]      inValid,
  input  logic [GROUP-1:0]      inHasDst,
  input  logic [GROUP*AW-1:0]   inSrcA,
  input  logic [GROUP*AW-1:0]   inSrcB,
  input  logic [GROUP*AW-1:0]   inDst,
  output logic                  outReady,
  output logic [GROUP*TW-1:0]   outSrcATag,
  output logic [GROUP*TW-1:0]   outSrcBTag,
  output logic [GROUP*TW-1:0]   outDstTag,
  output logic [GROUP*TW-1:0]   outOldTag,
  input  logic [GROUP-1:0]      retValid,
  input  logic [GROUP*AW-1:0]   retArch,
  input  logic [GROUP*TW-1:0]   retTag,
  input  logic [GROUP*TW-1:0]   retOldTag,
  input  logic                  flush
);
  ratStrobe_t         strobe;
  logic [PHYS-1:0]    freeVec;
  logic [PHYS-1:0]    commitUsed;
  logic [ARCH*TW-1:0] specFlat;
  logic [ARCH*TW-1:0] commitFlat;

  rat_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inHasDst(inHasDst),
    .retValid(retValid), .retOldTag(retOldTag), .flush(flush),
    .commitUsed(commitUsed), .strobe(strobe), .ready(outReady),
    .freeVec(freeVec)
  );

  rat_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inValid(inValid),
    .inHasDst(inHasDst), .inSrcA(inSrcA), .inSrcB(inSrcB), .inDst(inDst),
    .retValid(retValid), .retArch(retArch), .retTag(retTag),
    .outSrcATag(outSrcATag), .outSrcBTag(outSrcBTag),
    .outDstTag(outDstTag), .outOldTag(outOldTag),
    .commitUsed(commitUsed), .specFlat(specFlat), .commitFlat(commitFlat)
  );
endmodule

// File: rtl/rat_checker.sv
module rat_checker
  import rat_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [GROUP-1:0]    inValid,
  input logic [GROUP-1:0]    inHasDst,
  input logic                outReady,
  input logic [GROUP*TW-1:0] outDstTag,
  input logic                flush,
  input logic [PHYS-1:0]     freeVec,
  input logic [ARCH*TW-1:0]  specFlat,
  input logic [ARCH*TW-1:0]  commitFlat
);
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(freeVec) <= PHYS - ARCH); // R7

  AST_STALL_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(inValid & inHasDst) > $countones(freeVec)) |-> !outReady); // R6

  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !outReady); // R8

  AST_FLUSH_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (specFlat == commitFlat)); // R8

  for (genvar g = 0; g < GROUP; g++) begin : g_slot
    AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (outReady && inValid[g] && inHasDst[g]) |-> freeVec[outDstTag[g*TW +: TW]]); // R2

    AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (outReady && inValid[g] && inHasDst[g])
        |=> !freeVec[$past(outDstTag[g*TW +: TW])]); // R2

    for (genvar h = g + 1; h < GROUP; h++) begin : g_pair
      AST_DISTINCT_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (outReady && inValid[g] && inHasDst[g] && inValid[h] && inHasDst[h])
          |-> (outDstTag[g*TW +: TW] != outDstTag[h*TW +: TW])); // R2
    end
  end
endmodule

bind rat_top rat_checker u_checker (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inHasDst(inHasDst),
  .outReady(outReady), .outDstTag(outDstTag), .flush(flush),
  .freeVec(freeVec), .specFlat(specFlat), .commitFlat(commitFlat)
);

// File: tb/rat_top_bench.sv
module rat_top_bench;
  import rat_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [GROUP-1:0]    inValid = '0, inHasDst = '0, retValid = '0;
  logic [GROUP*AW-1:0] inSrcA = '0, inSrcB = '0, inDst = '0, retArch = '0;
  logic [GROUP*TW-1:0] retTag = '0, retOldTag = '0;
  logic                flush = 1'b0;
  logic                outReady;
  logic [GROUP*TW-1:0] outSrcATag, outSrcBTag, outDstTag, outOldTag;

  rat_top u_rat_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    bit ready; bit [GROUP-1:0] v; bit [GROUP-1:0] h;
    int a[GROUP]; int b[GROUP]; int d[GROUP]; int o[GROUP]; string req;
  } exp_t;
  typedef struct { int arch; int tag; int old; } ret_t;

  exp_t expQ[$];
  ret_t retQ[$];

  int  mSpec[ARCH], mCommit[ARCH];
  bit  mFree[PHYS];
  bit  gV[GROUP], gH[GROUP];
  int  gA[GROUP], gB[GROUP], gD[GROUP];

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int freeCount();
    int n = 0;
    for (int p = 0; p < PHYS; p++) n += mFree[p];
    return n;
  endfunction

  task automatic clearSlots();
    for (int g = 0; g < GROUP; g++) begin
      gV[g] = 0; gH[g] = 0; gA[g] = 0; gB[g] = 0; gD[g] = 0;
    end
  endtask

  task automatic setSlot(int g, bit v, bit h, int a, int b, int d);
    gV[g] = v; gH[g] = h; gA[g] = a; gB[g] = b; gD[g] = d;
  endtask

  // Driver: compute expectation from the model, drive one cycle, update model
  task automatic cycle(int nRet, bit fl, string req);
    exp_t e;
    bit   lf[PHYS];
    int   need = 0;
    ret_t r;
    for (int g = 0; g < GROUP; g++) need += (gV[g] && gH[g]);
    e.ready = !fl && (need <= freeCount());
    e.req = req;
    lf = mFree;
    for (int g = 0; g < GROUP; g++) begin
      e.v[g] = gV[g]; e.h[g] = gH[g];
      e.a[g] = mSpec[gA[g]]; e.b[g] = mSpec[gB[g]]; e.o[g] = mSpec[gD[g]]; e.d[g] = 0;
      for (int k = 0; k < g; k++)
        if (gV[k] && gH[k]) begin
          if (gD[k] == gA[g]) e.a[g] = e.d[k];
          if (gD[k] == gB[g]) e.b[g] = e.d[k];
          if (gD[k] == gD[g]) e.o[g] = e.d[k];
        end
      if (gV[g] && gH[g])
        for (int p = PHYS - 1; p >= 0; p--) if (lf[p]) e.d[g] = p;
      if (gV[g] && gH[g]) lf[e.d[g]] = 0;
    end
    for (int g = 0; g < GROUP; g++) begin
      inValid[g] = gV[g]; inHasDst[g] = gH[g];
      inSrcA[g*AW +: AW] = AW'(gA[g]); inSrcB[g*AW +: AW] = AW'(gB[g]);
      inDst[g*AW +: AW] = AW'(gD[g]);
    end
    retValid = '0;
    for (int g = 0; g < nRet; g++) begin
      r = retQ.pop_front();
      retValid[g] = 1'b1;
      retArch[g*AW +: AW] = AW'(r.arch);
      retTag[g*TW +: TW] = TW'(r.tag);
      retOldTag[g*TW +: TW] = TW'(r.old);
      mCommit[r.arch] = r.tag;
      mFree[r.old] = 1;
    end
    flush = fl;
    expQ.push_back(e);
    if (e.ready)
      for (int g = 0; g < GROUP; g++)
        if (gV[g] && gH[g]) begin
          mSpec[gD[g]] = e.d[g];
          mFree[e.d[g]] = 0;
          r.arch = gD[g]; r.tag = e.d[g]; r.old = e.o[g];
          retQ.push_back(r);
        end
    if (fl) begin
      mSpec = mCommit;
      for (int p = 0; p < PHYS; p++) mFree[p] = 1;
      for (int a = 0; a < ARCH; a++) mFree[mCommit[a]] = 0;
      retQ.delete();
    end
    @(posedge clk); #1;
    inValid = '0; inHasDst = '0; retValid = '0; flush = 1'b0;
    clearSlots();
  endtask

  // Monitor: compare at the falling edge of the cycle the item was driven
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.req, "outReady", int'(outReady), int'(e.ready));
      if (e.ready)
        for (int g = 0; g < GROUP; g++)
          if (e.v[g]) begin
            check(e.req, $sformatf("srcA[%0d]", g), int'(outSrcATag[g*TW +: TW]), e.a[g]);
            check(e.req, $sformatf("srcB[%0d]", g), int'(outSrcBTag[g*TW +: TW]), e.b[g]);
            if (e.h[g]) begin
              check(e.req, $sformatf("dst[%0d]", g), int'(outDstTag[g*TW +: TW]), e.d[g]);
              check(e.req, $sformatf("old[%0d]", g), int'(outOldTag[g*TW +: TW]), e.o[g]);
            end
          end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    for (int a = 0; a < ARCH; a++) begin mSpec[a] = a; mCommit[a] = a; end
    for (int p = 0; p < PHYS; p++) mFree[p] = (p >= ARCH);
    clearSlots();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: identity map after reset, reads only
    setSlot(0, 1, 0, 0, 1, 0); setSlot(1, 1, 0, 2, 3, 0); setSlot(2, 1, 0, 4, 7, 0);
    cycle(0, 0, "R1");
    // R1 R2: first allocation takes tags 8, 9, 10
    setSlot(0, 1, 1, 5, 6, 5); setSlot(1, 1, 1, 6, 7, 6); setSlot(2, 1, 1, 7, 0, 7);
    cycle(0, 0, "R2");
    // R3 R4: bypass and old tag inside the group
    setSlot(0, 1, 1, 1, 2, 1); setSlot(1, 1, 1, 1, 3, 2); setSlot(2, 1, 1, 2, 1, 1);
    cycle(0, 0, "R3");
    // R5: next group sees the new mappings, younger writer of r1 wins
    setSlot(0, 1, 0, 1, 2, 0); setSlot(1, 1, 0, 5, 7, 0);
    cycle(0, 0, "R5");
    // R9: invalid slot with dst and valid slot without dst take nothing
    setSlot(0, 0, 1, 0, 0, 4); setSlot(1, 1, 1, 4, 3, 3); setSlot(2, 1, 0, 3, 4, 6);
    cycle(0, 0, "R9");
    setSlot(0, 1, 0, 4, 6, 0); setSlot(1, 1, 1, 0, 0, 0);
    cycle(0, 0, "R9");
    // R2: drain the pool
    for (int i = 0; freeCount() > 3; i++) begin
      setSlot(0, 1, 1, i % 8, (i + 1) % 8, (i + 2) % 8);
      setSlot(1, 1, 1, (i + 2) % 8, i % 8, (i + 3) % 8);
      setSlot(2, 1, 1, (i + 3) % 8, (i + 5) % 8, (i + 4) % 8);
      cycle(0, 0, "R2");
    end
    // R6: exact fit accepted, then one short stalls and changes nothing
    for (int g = 0; g < GROUP; g++) setSlot(g, 1, g < freeCount(), g, g + 1, g + 3);
    cycle(0, 0, "R6");
    setSlot(0, 1, 1, 0, 1, 7);
    cycle(0, 0, "R6");
    setSlot(0, 1, 0, 7, 3, 0); setSlot(1, 1, 0, 4, 5, 0); setSlot(2, 1, 0, 6, 0, 0);
    cycle(0, 0, "R6");
    // R7: retire three, then their old tags are allocated again
    cycle(3, 0, "R7");
    setSlot(0, 1, 1, 1, 2, 1); setSlot(1, 1, 1, 3, 4, 2); setSlot(2, 1, 1, 5, 6, 3);
    cycle(0, 0, "R7");
    // R8: flush with two retirements and a pending group
    setSlot(0, 1, 1, 0, 1, 2);
    cycle(2, 1, "R8");
    setSlot(0, 1, 0, 0, 1, 0); setSlot(1, 1, 0, 2, 3, 0); setSlot(2, 1, 0, 4, 5, 0);
    cycle(0, 0, "R8");
    setSlot(0, 1, 1, 6, 7, 6); setSlot(1, 1, 1, 7, 6, 7); setSlot(2, 1, 1, 0, 0, 0);
    cycle(0, 0, "R8");
    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule